// File: doc/BRIEF.md
# Converter Start-Up Sequencer with Digital Soft-Start

This block orders the start of a step-down converter. Once the enable request and the supply-good flag are both high, it opens a timed window during which the external current-limit setting settles. At the end of the window it captures the digitized limit, clamping it to a built-in ceiling. It then ramps a digital reference code from zero up to a fixed target at a constant rate. The reference code feeds a DAC and the error comparator, which are outside this block.

If the output capacitor still carries charge from an earlier run, the feedback code can sit above zero when the ramp begins. To handle this, the sequencer keeps both power switches off until the ramp code catches up with the feedback code. Switching then starts from the level the output already has. Losing either the enable request or the supply-good flag at any time sends the sequencer back to idle. Idle clears the reference and the held limit.

The state machine has five states. `ST_IDLE` waits for enable and supply-good. `ST_SAMPLE` times the sampling window. `ST_PREBIAS` ramps with the switches held off. `ST_RAMP` ramps with switching allowed. `ST_REGULATE` holds the target. The transitions are:

- `ST_IDLE` to `ST_SAMPLE` when both conditions are met.
- `ST_SAMPLE` to `ST_PREBIAS` at window end.
- `ST_PREBIAS` to `ST_RAMP` when the ramp code is at or above the feedback code.
- `ST_PREBIAS` or `ST_RAMP` to `ST_REGULATE` when the ramp reaches the target.
- Any state to `ST_IDLE` when enable or supply-good is lost.

Top module: `startup_seq`

## Requirements
- R1: While reset is asserted, and afterwards until sequencing starts, `ref_code`, `ilim_held`, `sw_enable` and `ss_done` are all 0.
- R2: Sampling starts on the first clock edge at which `sys_enable` and `por_good` are both 1. It lasts exactly (`samp_set`×4+70)×CLK_PER_US cycles, where `samp_set` is the product of source current in µA and resistor in kΩ. During the window `ilim_held` stays 0 and switching stays off.
- R3: At the clock edge that ends the window, `ilim_held` takes `ilim_code` if `ilim_code` ≤ LIMIT_MAX (default 250). It takes LIMIT_MAX if `ilim_code` > LIMIT_MAX or if `ilim_open` is 1. It then holds that value until the sequencer returns to idle.
- R4: The ramp starts at code 0 on the edge that ends sampling. It rises by one every TICK = RAMP_CYC/TARGET_CODE cycles (default 12). It therefore reaches TARGET_CODE (default 500) exactly TARGET_CODE×TICK cycles after sampling ends, and never exceeds it.
- R5: `sw_enable` stays 0 while the ramp code is below `fb_code`. It rises on the clock edge after the ramp code first equals or exceeds `fb_code`. With `fb_code` = 0, this is one edge after sampling ends.
- R6: `ss_done` rises on the same edge that `ref_code` reaches TARGET_CODE. It stays 1 until the sequencer returns to idle.
- R7: If `sys_enable` or `por_good` is 0 at a clock edge, that edge returns the sequencer to idle, whatever its state. `ref_code`, `ilim_held`, `sw_enable` and `ss_done` become 0. A later start repeats the full sampling window.
- R8: If `fb_code` is above TARGET_CODE, switching stays off for the whole ramp. `sw_enable` then rises together with `ss_done`.
- R9: Once `sw_enable` is 1, it stays 1 while enabled, even if `fb_code` later rises above `ref_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sys_enable | input | 1 | Enable request |
| por_good | input | 1 | Supply above power-on threshold (hysteresis applied outside) |
| ilim_code | input | CODE_W | Digitized current-limit setting |
| ilim_open | input | 1 | Limit setting resistor detected open |
| samp_set | input | SET_W | Source current × resistor product setting the window length |
| fb_code | input | CODE_W | Digitized feedback level |
| ref_code | output | CODE_W | Soft-start reference code |
| ilim_held | output | CODE_W | Held, clamped current-limit code |
| sw_enable | output | 1 | Power switches allowed to operate |
| ss_done | output | 1 | Soft-start complete |

## Verification
The checker watches several rules on every cycle:

- The ramp moves only upward, one step at a time, and stops at the target.
- The held limit never exceeds the ceiling and does not change once captured.
- `sw_enable` and `ss_done` never fall while enabled, and `ss_done` implies the target code.
- A rising `sw_enable` is justified by the ramp having reached the feedback code, or by the end of soft-start.
- Any loss of enable clears every output on the next edge.

The exact length of the sampling window, the tick period, the cycle on which switching starts for a given pre-bias level, and the clamp and open-resistor choices can only be shown by the bench's timed scenarios.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SAMPLE   = 3'd1,
        ST_PREBIAS  = 3'd2,
        ST_RAMP     = 3'd3,
        ST_REGULATE = 3'd4
    } seq_state_t;

endpackage

// File: rtl/ss_window_timer.sv
module ss_window_timer #(
    parameter int SET_W      = 8,
    parameter int CLK_PER_US = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SET_W-1:0] setting,
    output logic             done
);
    localparam int MAX_LEN = (((1 << SET_W) - 1) * 4 + 70) * CLK_PER_US;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [31:0]      win_len;
    logic             last;

    // window length in cycles: (setting*4 + 70) microseconds
    assign win_len = (32'(setting) * 32'd4 + 32'd70) * 32'(CLK_PER_US);
    assign last    = (32'(cnt_q) == win_len - 32'd1);
    assign done    = run && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ss_limit_clamp.sv
module ss_limit_clamp #(
    parameter int CODE_W    = 10,
    parameter int LIMIT_MAX = 250
) (
    input  logic [CODE_W-1:0] raw_code,
    input  logic              open_det,
    output logic [CODE_W-1:0] clamped
);
    localparam logic [CODE_W-1:0] CEIL = CODE_W'(LIMIT_MAX);

    always_comb begin
        if (open_det || (raw_code > CEIL)) begin
            clamped = CEIL;
        end else begin
            clamped = raw_code;
        end
    end

endmodule

// File: rtl/ss_ramp_gen.sv
module ss_ramp_gen #(
    parameter int CODE_W      = 10,
    parameter int TARGET_CODE = 500,
    parameter int RAMP_CYC    = 6000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    output logic [CODE_W-1:0] code,
    output logic              hit
);
    localparam int TICK   = (RAMP_CYC / TARGET_CODE < 1) ? 1 : RAMP_CYC / TARGET_CODE;
    localparam int TICK_W = (TICK > 1) ? $clog2(TICK) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK - 1);
    localparam logic [CODE_W-1:0] TGT_M1    = CODE_W'(TARGET_CODE - 1);

    logic [TICK_W-1:0] tick_q;
    logic [CODE_W-1:0] code_q;
    logic              wrap;

    assign wrap = (tick_q == TICK_LAST);
    assign hit  = run && wrap && (code_q == TGT_M1);
    assign code = code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            code_q <= '0;
        end else if (clear) begin
            tick_q <= '0;
            code_q <= '0;
        end else if (run) begin
            if (wrap) begin
                tick_q <= '0;
                code_q <= code_q + 1'b1;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/startup_seq.sv
module startup_seq
    import startup_seq_pkg::*;
#(
    parameter int CODE_W      = 10,
    parameter int SET_W       = 8,
    parameter int CLK_PER_US  = 4,
    parameter int TARGET_CODE = 500,
    parameter int RAMP_CYC    = 6000,
    parameter int LIMIT_MAX   = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_enable,
    input  logic              por_good,
    input  logic [CODE_W-1:0] ilim_code,
    input  logic              ilim_open,
    input  logic [SET_W-1:0]  samp_set,
    input  logic [CODE_W-1:0] fb_code,
    output logic [CODE_W-1:0] ref_code,
    output logic [CODE_W-1:0] ilim_held,
    output logic              sw_enable,
    output logic              ss_done
);
    seq_state_t        state_q, state_d;
    logic              go_ok;
    logic              win_run, win_done;
    logic              ramp_clear, ramp_run, ramp_hit;
    logic [CODE_W-1:0] ramp_code;
    logic [CODE_W-1:0] lim_clamped;
    logic [CODE_W-1:0] held_q;

    assign go_ok = sys_enable && por_good;

    ss_window_timer #(
        .SET_W     (SET_W),
        .CLK_PER_US(CLK_PER_US)
    ) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (win_run),
        .setting(samp_set),
        .done   (win_done)
    );

    ss_limit_clamp #(
        .CODE_W   (CODE_W),
        .LIMIT_MAX(LIMIT_MAX)
    ) u_clamp (
        .raw_code(ilim_code),
        .open_det(ilim_open),
        .clamped (lim_clamped)
    );

    ss_ramp_gen #(
        .CODE_W     (CODE_W),
        .TARGET_CODE(TARGET_CODE),
        .RAMP_CYC   (RAMP_CYC)
    ) u_ramp (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(ramp_clear),
        .run  (ramp_run),
        .code (ramp_code),
        .hit  (ramp_hit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!go_ok) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_SAMPLE;
                ST_SAMPLE:   if (win_done) state_d = ST_PREBIAS;
                ST_PREBIAS: begin
                    if (ramp_hit) begin
                        state_d = ST_REGULATE;
                    end else if (ramp_code >= fb_code) begin
                        state_d = ST_RAMP;
                    end
                end
                ST_RAMP:     if (ramp_hit) state_d = ST_REGULATE;
                ST_REGULATE: state_d = ST_REGULATE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register and held limit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (!go_ok) begin
                held_q <= '0;
            end else if (state_q == ST_SAMPLE && win_done) begin
                held_q <= lim_clamped;
            end
        end
    end

    // outputs and sub-block controls
    always_comb begin
        win_run    = 1'b0;
        ramp_clear = 1'b1;
        ramp_run   = 1'b0;
        sw_enable  = 1'b0;
        ss_done    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SAMPLE:   win_run = go_ok;
            ST_PREBIAS: begin
                ramp_clear = !go_ok;
                ramp_run   = go_ok;
            end
            ST_RAMP: begin
                ramp_clear = !go_ok;
                ramp_run   = go_ok;
                sw_enable  = 1'b1;
            end
            ST_REGULATE: begin
                ramp_clear = !go_ok;
                sw_enable  = 1'b1;
                ss_done    = 1'b1;
            end
            default: ;
        endcase
        ref_code  = ramp_code;
        ilim_held = held_q;
    end

endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk #(
    parameter int CODE_W      = 10,
    parameter int TARGET_CODE = 500,
    parameter int LIMIT_MAX   = 250
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sys_enable,
    input logic              por_good,
    input logic [CODE_W-1:0] fb_code,
    input logic [CODE_W-1:0] ref_code,
    input logic [CODE_W-1:0] ilim_held,
    input logic              sw_enable,
    input logic              ss_done
);
    logic en_ok;
    assign en_ok = sys_enable && por_good;

    a_r7_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en_ok |=> (ref_code == '0 && ilim_held == '0 && !sw_enable && !ss_done));

    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_ok) && ref_code != $past(ref_code)) |-> ref_code == $past(ref_code) + 1'b1);

    a_r4_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
        ref_code <= CODE_W'(TARGET_CODE));

    a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_done && en_ok) |=> ss_done);

    a_r6_done_at_target: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |-> ref_code == CODE_W'(TARGET_CODE));

    a_r5_switch_justified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_enable) |-> ($past(ref_code) >= $past(fb_code)) || ss_done);

    a_r9_switch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_enable && en_ok) |=> sw_enable);

    a_r3_limit_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_held <= CODE_W'(LIMIT_MAX));

    a_r3_limit_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_ok) && $past(ilim_held) != '0) |-> $stable(ilim_held));

endmodule

bind startup_seq startup_seq_chk #(
    .CODE_W     (CODE_W),
    .TARGET_CODE(TARGET_CODE),
    .LIMIT_MAX  (LIMIT_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_enable(sys_enable),
    .por_good  (por_good),
    .fb_code   (fb_code),
    .ref_code  (ref_code),
    .ilim_held (ilim_held),
    .sw_enable (sw_enable),
    .ss_done   (ss_done)
);

// File: tb/startup_seq_test.sv
module startup_seq_test;
    localparam int TGT  = 500;
    localparam int TICK = 12;
    localparam int CPU  = 4;

    typedef struct packed {
        logic [7:0] set;
        logic [9:0] lim;
        logic       open;
        logic [9:0] fb;
        logic [9:0] exp_lim;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{8'd0,  10'd120,  1'b0, 10'd0,   10'd120},
        '{8'd3,  10'd250,  1'b0, 10'd37,  10'd250},
        '{8'd10, 10'd251,  1'b0, 10'd200, 10'd250},
        '{8'd1,  10'd90,   1'b1, 10'd499, 10'd250},
        '{8'd25, 10'd1023, 1'b0, 10'd1,   10'd250}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sys_enable, por_good, ilim_open;
    logic [9:0] ilim_code, fb_code, ref_code, ilim_held;
    logic [7:0] samp_set;
    logic       sw_enable, ss_done;
    int         total = 0;
    int         bad = 0;
    bit         finished = 1'b0;

    always #4 clk = ~clk;

    startup_seq uut (
        .clk(clk), .rst_n(rst_n), .sys_enable(sys_enable), .por_good(por_good),
        .ilim_code(ilim_code), .ilim_open(ilim_open), .samp_set(samp_set),
        .fb_code(fb_code), .ref_code(ref_code), .ilim_held(ilim_held),
        .sw_enable(sw_enable), .ss_done(ss_done)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    function automatic int win_of(input int s);
        return (s * 4 + 70) * CPU;
    endfunction

    task automatic start(input int s, input int lim, input bit op, input int fb);
        sys_enable = 1'b0;
        cyc(2);
        samp_set  = 8'(s);
        ilim_code = 10'(lim);
        ilim_open = op;
        fb_code   = 10'(fb);
        por_good  = 1'b1;
        sys_enable = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; sys_enable = 1'b0; por_good = 1'b0; ilim_open = 1'b0;
        ilim_code = '0; fb_code = '0; samp_set = '0;
        @(negedge clk);
        check("R1 ref in reset", int'(ref_code), 0);
        check("R1 sw in reset", int'(sw_enable), 0);
        cyc(2);
        rst_n = 1'b1;
        cyc(5);
        check("R1 held idle", int'(ilim_held), 0);
        check("R1 done idle", int'(ss_done), 0);

        // vector walk
        for (int v = 0; v < 5; v++) begin
            int w, fb, t;
            w  = win_of(int'(VECS[v].set));
            fb = int'(VECS[v].fb);
            start(int'(VECS[v].set), int'(VECS[v].lim), VECS[v].open, fb);
            cyc(w);
            check("R2 held during window", int'(ilim_held), 0);
            check("R2 no switching in window", int'(sw_enable), 0);
            cyc(1);
            check("R3 held limit", int'(ilim_held), int'(VECS[v].exp_lim));
            check("R4 ramp starts at zero", int'(ref_code), 0);
            if (fb > 0) begin
                cyc(fb * TICK);
                check("R4 ramp code at fb", int'(ref_code), fb);
                check("R5 switch off below fb", int'(sw_enable), 0);
            end
            cyc(1);
            check("R5 switch on after fb", int'(sw_enable), 1);
            t = fb * TICK + 1;
            cyc(TGT * TICK - 1 - t);
            check("R6 done not early", int'(ss_done), 0);
            check("R4 code before end", int'(ref_code), TGT - 1);
            cyc(1);
            check("R6 done at target", int'(ss_done), 1);
            check("R4 code at target", int'(ref_code), TGT);
            cyc(20);
            check("R6 done held", int'(ss_done), 1);
            check("R4 code held", int'(ref_code), TGT);
        end

        // R2: enable without supply good does nothing; window counts from por rise
        sys_enable = 1'b0; cyc(2);
        samp_set = 8'd0; ilim_code = 10'd77; ilim_open = 1'b0; fb_code = '0;
        por_good = 1'b0; sys_enable = 1'b1;
        cyc(400);
        check("R2 no start without por", int'(ilim_held), 0);
        check("R2 no ramp without por", int'(sw_enable), 0);
        por_good = 1'b1;
        cyc(win_of(0));
        check("R2 window length", int'(ilim_held), 0);
        cyc(1);
        check("R2 window end", int'(ilim_held), 77);

        // R7: drop mid-ramp
        cyc(TICK * 40);
        check("R7 ramping before drop", int'(ref_code), 40);
        por_good = 1'b0;
        cyc(1);
        check("R7 ref cleared", int'(ref_code), 0);
        check("R7 held cleared", int'(ilim_held), 0);
        check("R7 sw cleared", int'(sw_enable), 0);

        // R7: drop during sampling restarts full window
        start(2, 60, 1'b0, 0);
        cyc(100);
        sys_enable = 1'b0;
        cyc(1);
        sys_enable = 1'b1;
        cyc(win_of(2));
        check("R7 window restarted", int'(ilim_held), 0);
        cyc(1);
        check("R7 held after restart", int'(ilim_held), 60);

        // R8: feedback above target
        start(0, 100, 1'b0, 1023);
        cyc(win_of(0) + 1);
        cyc(TGT * TICK - 1);
        check("R8 switch off whole ramp", int'(sw_enable), 0);
        cyc(1);
        check("R8 switch with done", int'(sw_enable), 1);
        check("R8 done", int'(ss_done), 1);

        // R7: drop after done
        sys_enable = 1'b0;
        cyc(1);
        check("R7 done cleared", int'(ss_done), 0);

        // R9: switching sticky against rising feedback
        start(0, 100, 1'b0, 0);
        cyc(win_of(0) + 2);
        check("R9 switching on", int'(sw_enable), 1);
        fb_code = 10'd1023;
        cyc(30);
        check("R9 switching stays on", int'(sw_enable), 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule